// File: doc/BRIEF.md
# Serial PHY Management Frame Engine

This block runs the two-wire PHY management bus (MDC clock and bidirectional MDIO data) from a single 32-bit command word. Software writes the word once. The engine then sends a 32-bit run of ones, followed by every bit of the word, most significant bit first. During a read, it releases the data line for the turnaround and the data phase. It captures the sixteen bits the PHY returns into the low half of the same word. An idle flag shows when the frame has fully finished, and software polls that flag before it reads the result.

The MDC clock is the system clock divided by 8, 16, 32 or 64. A 2-bit select picks the ratio, so the integrator can keep MDC at or below 2.5 MHz. A port-enable input gates the bus. While the enable is low, MDC and the MDIO driver stay quiet and the frame is frozen in place. The frame resumes where it stopped when the enable returns.

Command word layout: [31:30] start code 01, [29:28] opcode (10 = read, any other value is sent as a write), [27:23] PHY address, [22:18] register address, [17:16] turnaround 10, [15:0] data.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: After reset `idle`=1, `mdc`=0, `mdio_oe`=0, `mdio_out`=0 and `reg_rdata`=0.
- R2: During a frame, one MDC period lasts D = 8<<`clk_sel` system clocks. MDC is low for the first D/2 clocks and high for the last D/2 clocks.
- R3: While `port_en`=0, `mdc` and `mdio_oe` are 0 and frame progress is frozen. The frame continues from the same point when `port_en` returns to 1.
- R4: A `reg_wr` pulse while idle loads `reg_wdata` into the command word. `idle` reads 0 from the next cycle.
- R5: `mdio_out` carries 32 ones and then command word bits 31 down to 0. Each bit lasts one MDC period and changes at the start of the low half.
- R6: In a read frame (bits [29:28]=10), `mdio_oe` is 0 from the second turnaround bit (word bit 16) to the end of the frame. `mdio_in` is sampled at each MDC rising edge of data bits 15 down to 0, and each sample is stored into the matching bit of `reg_rdata`. Bits [31:16] are unchanged.
- R7: In a write frame, `mdio_oe` is 1 for all 64 bits and the command word keeps its value.
- R8: `idle` returns to 1 exactly 64·D clocks after the load, provided `port_en` stays 1.
- R9: A `reg_wr` while a frame is in progress has no effect on the word or on the frame.
- R10: `clk_sel` is captured at the load. Changing it during a frame does not change that frame's MDC period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Management port enable |
| clk_sel | input | 2 | MDC divide select: 0→8, 1→16, 2→32, 3→64 |
| reg_wr | input | 1 | Command word write strobe |
| reg_wdata | input | 32 | Command word write data |
| reg_rdata | output | 32 | Command word, with read data in [15:0] after a read |
| idle | output | 1 | 1 when no frame is in progress |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO drive value |
| mdio_oe | output | 1 | MDIO driver enable |
| mdio_in | input | 1 | MDIO input from the pad |

## Verification
The bench builds the engine with the default 32-bit preamble. It drives all four divide selects in turn, so the shortest and the longest MDC periods are both compared cycle by cycle against a behavioural model. One long read frame at ratio 64 gives the bench room to pause the port, to write during the frame and to change the divide select while the frame is in progress. The bench also acts as the PHY: it returns a known pattern, so that the data captured on the rising edges can be checked bit for bit against the pattern.

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine #(
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        port_en,
  input  logic [1:0]  clk_sel,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        idle,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  localparam int FRAME_BITS = PRE_BITS + 32;
  localparam int BW = $clog2(FRAME_BITS);

  logic          busy;
  logic [31:0]   mreg;
  logic [BW-1:0] bit_idx;
  logic [5:0]    ph;
  logic [1:0]    dsel;

  wire [6:0] div_n   = 7'd8 << dsel;
  wire [6:0] half_n  = div_n >> 1;
  wire       run     = busy & port_en;
  wire       bit_end = ({1'b0, ph} == div_n - 7'd1);
  wire       rise    = ({1'b0, ph} == half_n - 7'd1);
  wire       in_pre  = bit_idx < BW'(PRE_BITS);
  wire [4:0] fpos    = 5'(bit_idx - BW'(PRE_BITS));
  wire [4:0] widx    = ~fpos;
  wire       rd_op   = (mreg[29:28] == 2'b10);
  wire       released = rd_op & ~in_pre & (fpos >= 5'd15);

  assign mdc       = run & ({1'b0, ph} >= half_n);
  assign mdio_oe   = run & ~released;
  assign mdio_out  = mdio_oe & (in_pre | mreg[widx]);
  assign idle      = ~busy;
  assign reg_rdata = mreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      mreg    <= '0;
      bit_idx <= '0;
      ph      <= '0;
      dsel    <= '0;
    end else if (!busy) begin
      if (reg_wr) begin
        mreg    <= reg_wdata;
        busy    <= 1'b1;
        bit_idx <= '0;
        ph      <= '0;
        dsel    <= clk_sel;
      end
    end else if (port_en) begin
      if (rise && released && fpos >= 5'd16)
        mreg[widx] <= mdio_in;
      if (bit_end) begin
        ph <= '0;
        if (bit_idx == BW'(FRAME_BITS - 1)) busy <= 1'b0;
        else bit_idx <= bit_idx + 1'b1;
      end else begin
        ph <= ph + 6'd1;
      end
    end
  end

  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!mdc && !mdio_oe));
  a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_en && busy) |=> ($stable(bit_idx) && $stable(ph) && $stable(mreg)));
  a_r4_start: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && reg_wr) |=> (!idle && reg_rdata == $past(reg_wdata)));
  a_r9_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && reg_wr) |=> (reg_rdata[31:16] == $past(reg_rdata[31:16])));
  a_r7_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !rd_op) |=> $stable(reg_rdata));
  a_r6_release_only_read: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !mdio_oe) |-> rd_op);
  a_r10_div_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$rose(busy)) |-> $stable(dsel));
endmodule

// File: tb/mdio_mgmt_engine_tb_top.sv
module mdio_mgmt_engine_tb_top;
  logic clk = 0, rst_n = 0, port_en = 1, reg_wr = 0, mdio_in = 1;
  logic [1:0] clk_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic idle, mdc, mdio_out, mdio_oe;
  int total = 0, bad = 0;
  logic [15:0] phy_word = 16'h0;

  always #2 clk = ~clk;

  mdio_mgmt_engine dut_i (.clk(clk), .rst_n(rst_n), .port_en(port_en), .clk_sel(clk_sel),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .idle(idle),
    .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in));

  bit m_busy = 0;
  int m_bit = 0, m_ph = 0, m_d = 8;
  logic [31:0] m_reg = 0;

  function automatic bit m_read(); return m_reg[29:28] == 2'b10; endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      if (m_busy) begin
        if (port_en) begin
          if (m_ph == m_d/2 - 1 && m_read() && m_bit >= 48) m_reg[63 - m_bit] = mdio_in;
          if (m_ph == m_d - 1) begin
            m_ph = 0;
            if (m_bit == 63) m_busy = 0; else m_bit++;
          end else m_ph++;
        end
      end else if (reg_wr) begin
        m_reg = reg_wdata; m_busy = 1; m_bit = 0; m_ph = 0; m_d = 8 << clk_sel;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_oe, e_mdc, e_out;
      e_mdc = m_busy && port_en && m_ph >= m_d/2;
      e_oe  = m_busy && port_en && !(m_read() && m_bit >= 47);
      e_out = e_oe && (m_bit < 32 || m_reg[63 - m_bit]);
      chk("R2 mdc", {31'b0, mdc}, {31'b0, e_mdc});
      chk("R6 mdio_oe", {31'b0, mdio_oe}, {31'b0, e_oe});
      chk("R5 mdio_out", {31'b0, mdio_out}, {31'b0, e_out});
      chk("R8 idle", {31'b0, idle}, {31'b0, !m_busy});
      chk("R7 reg_rdata", reg_rdata, m_reg);
      mdio_in = (m_busy && m_read() && m_bit >= 48) ? phy_word[63 - m_bit] : 1'b1;
    end
  end

  task automatic start(logic [31:0] cmd, logic [1:0] sel);
    @(negedge clk);
    reg_wdata = cmd; clk_sel = sel; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
    chk("R4 busy after load", {31'b0, idle}, 32'd0);
  endtask

  task automatic wait_idle(output int n);
    n = 1;
    while (!idle) begin @(negedge clk); n++; end
    n--;
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    logic [31:0] c;
    repeat (3) @(negedge clk);
    chk("R1 idle", {31'b0, idle}, 32'd1);
    chk("R1 mdc/oe/out", {29'b0, mdc, mdio_oe, mdio_out}, 32'd0);
    chk("R1 rdata", reg_rdata, 32'd0);
    rst_n = 1;

    c = {2'b01, 2'b01, 5'd3, 5'd1, 2'b10, 16'hA5C3};
    start(c, 2'd0); wait_idle(n);
    chk("R8 frame length D=8", n, 64 * 8);
    chk("R7 write keeps word", reg_rdata, c);

    phy_word = 16'h3C5A;
    c = {2'b01, 2'b10, 5'd17, 5'd2, 2'b10, 16'hFFFF};
    start(c, 2'd1); wait_idle(n);
    chk("R8 frame length D=16", n, 64 * 16);
    chk("R6 read data", reg_rdata, {c[31:16], 16'h3C5A});

    phy_word = 16'h9E61;
    c = {2'b01, 2'b10, 5'd31, 5'd30, 2'b10, 16'h0000};
    start(c, 2'd3);
    repeat (100) @(negedge clk);
    reg_wdata = 32'h5555_1234; reg_wr = 1; clk_sel = 2'd0;
    @(negedge clk); reg_wr = 0;
    chk("R9 write while busy ignored", reg_rdata[31:16], c[31:16]);
    repeat (1500) @(negedge clk);
    port_en = 0;
    repeat (300) begin
      @(negedge clk);
      chk("R3 quiet while disabled", {30'b0, mdc, mdio_oe}, 32'd0);
    end
    port_en = 1;
    wait_idle(n);
    chk("R6 read data after pause", reg_rdata, {c[31:16], 16'h9E61});

    c = {2'b01, 2'b01, 5'd8, 5'd4, 2'b10, 16'h0F0F};
    start(c, 2'd2);
    clk_sel = 2'd0;
    wait_idle(n);
    chk("R10 divide held at load", n, 64 * 32);
    chk("R7 write keeps word", reg_rdata, c);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule